// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital front end of a 12-bit successive-approximation converter that is reached over a four-wire serial port. All logic runs on a fast system clock. The chip select, serial clock and data input are brought into that clock domain through a synchronizer, and edges of the serial clock are detected there.

A conversion begins only when a start bit opens an 8-bit control byte. The byte's fields set the input range, the polarity, a two-bit mode, power-down and the reference source. These settings are held on registered outputs. Counting serial clocks from the start bit, the block ends acquisition with a one-cycle sample strobe. At that strobe it captures a parallel result word, which stands in for the analog core, and then shifts the word out MSB first.

A start bit can cut short a conversion whose upper bits are still leaving the block. Once result bit D4 has gone out, the next control byte overlaps the remaining result bits, so one conversion can be done every 16 serial clocks.

Top module: `sar_serial_seq`

## Requirements
- R1: After reset, `dout` and `dout_oe` are 0 and every configuration output is 0. This means full power, external reference, range 0, unipolar and mode 0.
- R2: DIN is sampled on each rising SCLK edge while CS is low. The start bit is the first 1 seen when no byte is in progress, and zeros before it are ignored. A falling CS with no start bit never produces a sample strobe.
- R3: The control byte is sent in this order: start, range, bipolar, mode[1], mode[0], power-down, reserved, reference select (1 = internal). The outputs `range_sel`, `bipolar`, `mode`, `pwr_down` and `ref_int` change only after all 8 bits have arrived. A byte cut short by CS going high changes nothing.
- R4: `sample_stb` is high for exactly one system clock, following the 8th SCLK falling edge counted from the start bit. `result_i` is captured at that moment, so later changes to it do not affect the bits shifted out.
- R5: The captured word leaves on `dout` MSB first. D11 appears after SCLK falling edge 9 and D0 after edge 20, counted from the start bit.
- R6: After D0, every further SCLK falling edge drives 0 on `dout`.
- R7: While CS is high, `dout_oe` is 0, `dout` is 0, SCLK edges are ignored and any byte or conversion in progress is dropped.
- R8: A start bit sampled before D4 has been driven (rising edges 9 to 16) abandons the running conversion. `dout` then shows 0 until the new conversion's D11 appears.
- R9: A start bit sampled once D4 has been driven (rising edge 17 or later) begins a new byte. D3 to D0 of the running conversion still come out, giving one conversion per 16 SCLKs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial control input |
| result_i | input | RES_W | Parallel conversion result from the core model |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for the serial output pad |
| sample_stb | output | 1 | One-cycle end-of-acquisition strobe |
| range_sel | output | 1 | Input range select |
| bipolar | output | 1 | 1 = bipolar input, 0 = unipolar |
| mode | output | 2 | Operating mode field |
| pwr_down | output | 1 | Power-down request |
| ref_int | output | 1 | 1 = internal reference, 0 = external |

## Verification
A single conversion is run after a few leading zeros, which shows whether the start bit is found where it should be and whether the strobe falls on the right edge. Back-to-back bytes with the start bit on rising edge 17 check that the overlapping bits D3..D0 survive, while a start bit on rising edge 16 checks that an unfinished conversion is abandoned. This pair separates the two sides of the D4 boundary. Changing `result_i` right after each strobe, cutting a byte short with CS, and clocking ones while CS is high show which inputs are captured and which are ignored.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // Serial control frame length including the start bit.
  localparam int CTRL_BITS = 8;
  // Result bit index after which a start bit no longer aborts.
  localparam int LATE_BIT  = 4;

  typedef struct packed {
    logic       range_sel;
    logic       bipolar;
    logic [1:0] mode;
    logic       pwr_down;
    logic       ref_int;
  } cfg_t;
endpackage

// File: rtl/sar_seq_sync.sv
module sar_seq_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sar_seq_rx.sv
module sar_seq_rx
  import sar_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic rise,
  input  logic din,
  output logic start_hit,
  output logic byte_done,
  output cfg_t fields
);
  localparam int PAY   = CTRL_BITS - 1;      // bits after start
  localparam int CNT_W = $clog2(CTRL_BITS);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [PAY-2:0]   sh;                      // holds all but the last payload bit

  assign start_hit = rise & ~active & din;
  assign byte_done = rise & active & (cnt == CNT_W'(PAY - 1));

  // The last payload bit (reference select) is taken straight from din.
  assign fields = '{range_sel: sh[5], bipolar: sh[4], mode: sh[3:2],
                    pwr_down: sh[1], ref_int: din};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else if (rise) begin
      if (!active) begin
        if (din) begin
          active <= 1'b1;
          cnt    <= '0;
        end
      end else begin
        sh <= {sh[PAY-3:0], din};
        if (cnt == CNT_W'(PAY - 1)) begin
          active <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq_tx.sv
module sar_seq_tx
  import sar_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             start_hit,
  input  logic             byte_done,
  input  logic             fall,
  input  logic [RES_W-1:0] result_i,
  output logic             dout,
  output logic             sample_stb
);
  localparam int CW          = $clog2(RES_W + 1);
  localparam int ABORT_LIMIT = RES_W - LATE_BIT;   // bits driven up to and incl. D4

  logic             pending;
  logic             live;
  logic [CW-1:0]    cnt;
  logic [RES_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pending    <= 1'b0;
      live       <= 1'b0;
      cnt        <= '0;
      sh         <= '0;
      dout       <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      if (byte_done) pending <= 1'b1;
      if (start_hit && live && (cnt < CW'(ABORT_LIMIT))) begin
        live <= 1'b0;
        sh   <= '0;
      end
      if (fall) begin
        if (pending) begin
          pending    <= 1'b0;
          sample_stb <= 1'b1;
          sh         <= result_i;
          cnt        <= '0;
          live       <= 1'b1;
          dout       <= 1'b0;
        end else begin
          dout <= sh[RES_W-1];
          sh   <= {sh[RES_W-2:0], 1'b0};
          if (live) begin
            if (cnt == CW'(RES_W - 1)) live <= 1'b0;
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic [RES_W-1:0] result_i,
  output logic             dout,
  output logic             dout_oe,
  output logic             sample_stb,
  output logic             range_sel,
  output logic             bipolar,
  output logic [1:0]       mode,
  output logic             pwr_down,
  output logic             ref_int
);
  logic cs_q, sclk_q, din_q, sclk_d;
  logic sclk_rise, sclk_fall;
  logic start_hit, byte_done;
  cfg_t fields, cfg_q;

  sar_seq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sclk, din}),
    .q   ({cs_q, sclk_q, din_q})
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_q;
  end

  assign sclk_rise = ~cs_q &  sclk_q & ~sclk_d;
  assign sclk_fall = ~cs_q & ~sclk_q &  sclk_d;

  sar_seq_rx u_rx (
    .clk       (clk),
    .rst       (rst),
    .clear     (cs_q),
    .rise      (sclk_rise),
    .din       (din_q),
    .start_hit (start_hit),
    .byte_done (byte_done),
    .fields    (fields)
  );

  sar_seq_tx #(.RES_W(RES_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .clear      (cs_q),
    .start_hit  (start_hit),
    .byte_done  (byte_done),
    .fall       (sclk_fall),
    .result_i   (result_i),
    .dout       (dout),
    .sample_stb (sample_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= ~cs_q;
      if (byte_done) cfg_q <= fields;
    end
  end

  assign range_sel = cfg_q.range_sel;
  assign bipolar   = cfg_q.bipolar;
  assign mode      = cfg_q.mode;
  assign pwr_down  = cfg_q.pwr_down;
  assign ref_int   = cfg_q.ref_int;
endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_q,
  input logic       sclk_fall,
  input logic       byte_done,
  input logic       sample_stb,
  input logic       dout,
  input logic       dout_oe,
  input logic [5:0] cfg_bits
);
  AST_CFG_ONLY_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_done) |-> $stable(cfg_bits)); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb); // R4

  AST_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> $past(sclk_fall)); // R4

  AST_HIZ_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !dout_oe); // R7

  AST_DOUT_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !dout); // R7
endmodule

bind sar_serial_seq sar_serial_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_q       (cs_q),
  .sclk_fall  (sclk_fall),
  .byte_done  (byte_done),
  .sample_stb (sample_stb),
  .dout       (dout),
  .dout_oe    (dout_oe),
  .cfg_bits   ({range_sel, bipolar, mode, pwr_down, ref_int})
);

// File: tb/sar_serial_seq_tb_top.sv
module sar_serial_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [11:0] result_i;
  logic        dout, dout_oe, sample_stb;
  logic        range_sel, bipolar, pwr_down, ref_int;
  logic [1:0]  mode;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int stb_cnt  = 0;
  int stb_base = 0;
  int stb_cyc [0:7];
  logic        dq [0:63];
  logic [11:0] res_list [0:3];
  bit          done = 0;

  always #10 clk = ~clk;

  sar_serial_seq dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .result_i(result_i), .dout(dout), .dout_oe(dout_oe),
    .sample_stb(sample_stb), .range_sel(range_sel), .bipolar(bipolar),
    .mode(mode), .pwr_down(pwr_down), .ref_int(ref_int)
  );

  always @(posedge clk) begin
    if (sample_stb) begin
      stb_cyc[(stb_cnt - stb_base) & 7] = cyc;
      stb_cnt = stb_cnt + 1;
    end
  end

  always @(negedge clk) begin
    int k;
    k = stb_cnt - stb_base;
    result_i = res_list[(k > 3) ? 3 : k];
  end

  function automatic logic [5:0] cfg_now();
    return {range_sel, bipolar, mode, pwr_down, ref_int};
  endfunction

  function automatic logic [11:0] collect(input int first, input int n);
    logic [11:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[10:0], dq[first + i]};
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One SCLK period: drive din, rise, fall, then sample dout well after the fall.
  task automatic tick(input logic d);
    cyc++;
    @(negedge clk); din = d;
    repeat (7) @(negedge clk); sclk = 1'b1;
    repeat (8) @(negedge clk); sclk = 1'b0;
    repeat (7) @(negedge clk);
    dq[cyc] = dout;
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) tick(b[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  task automatic begin_run(input logic [11:0] r0, input logic [11:0] r1);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    res_list[0] = r0; res_list[1] = r1; res_list[2] = 12'h000; res_list[3] = 12'h000;
    stb_base = stb_cnt;
    cyc = 0;
    for (int i = 0; i < 64; i++) dq[i] = 1'bx;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(dout_oe == 1'b0, "R1", "oe after reset", dout_oe, 0);
    chk(dout == 1'b0, "R1", "dout after reset", dout, 0);
    chk(cfg_now() == 6'b0, "R1", "config after reset", cfg_now(), 0);
    begin_run(12'h123, 12'h000);
    repeat (40) @(negedge clk);
    chk(dout_oe == 1'b1, "R7", "oe with CS low", dout_oe, 1);
    chk(stb_cnt == stb_base, "R2", "no strobe from CS fall", stb_cnt - stb_base, 0);
    idle(10);
    chk(stb_cnt == stb_base, "R2", "zeros start nothing", stb_cnt - stb_base, 0);
  endtask

  task automatic t_single;
    logic [11:0] r = 12'hA5C;
    begin_run(r, 12'h3C3);
    idle(3);
    for (int i = 7; i >= 1; i--) tick(((8'hD5 >> i) & 8'h1) != 0);
    chk(cfg_now() == 6'b0, "R3", "config before 8th bit", cfg_now(), 0);
    tick(1'b1);
    repeat (4) @(negedge clk);
    chk(cfg_now() == 6'b101011, "R3", "decoded fields", cfg_now(), 6'b101011);
    idle(15);
    chk(stb_cnt - stb_base == 1, "R4", "strobe count", stb_cnt - stb_base, 1);
    chk(stb_cyc[0] == 11, "R2", "strobe after leading zeros", stb_cyc[0], 11);
    chk(collect(12, 12) == r, "R5", "result MSB first", collect(12, 12), r);
    chk(collect(24, 3) == 12'h0, "R6", "trailing zeros", collect(24, 3), 0);
  endtask

  task automatic t_back_to_back;
    logic [11:0] r1 = 12'h9E1;
    logic [11:0] r2 = 12'h6B4;
    begin_run(r1, r2);
    send(8'h80);
    idle(8);
    send(8'hAA);
    idle(14);
    chk(stb_cyc[0] == 8 && stb_cyc[1] == 24, "R9", "strobes 16 apart",
        stb_cyc[1] - stb_cyc[0], 16);
    chk(collect(9, 12) == r1, "R9", "first result with overlap", collect(9, 12), r1);
    chk(collect(25, 12) == r2, "R4", "second result captured at strobe",
        collect(25, 12), r2);
    chk(cfg_now() == 6'b010100, "R3", "second byte fields", cfg_now(), 6'b010100);
  endtask

  task automatic t_abort;
    logic [11:0] r1 = 12'hFFF;
    logic [11:0] r2 = 12'h5A6;
    begin_run(r1, r2);
    send(8'hC1);
    idle(7);
    send(8'h86);
    idle(14);
    chk(collect(9, 7) == {5'b0, r1[11:5]}, "R8", "bits before abort",
        collect(9, 7), {5'b0, r1[11:5]});
    chk(collect(16, 8) == 12'h0, "R8", "zeros after abort", collect(16, 8), 0);
    chk(stb_cyc[1] == 23, "R8", "restart strobe", stb_cyc[1], 23);
    chk(collect(24, 12) == r2, "R8", "restarted result", collect(24, 12), r2);
    chk(cfg_now() == 6'b000010, "R3", "restart byte fields", cfg_now(), 6'b000010);
  endtask

  task automatic t_deselect;
    begin_run(12'h777, 12'h000);
    tick(1'b1); tick(1'b1); tick(1'b1); tick(1'b1);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(dout_oe == 1'b0, "R7", "oe with CS high", dout_oe, 0);
    chk(dout == 1'b0, "R7", "dout with CS high", dout, 0);
    for (int i = 0; i < 10; i++) tick(1'b1);
    chk(stb_cnt == stb_base, "R7", "SCLK ignored with CS high", stb_cnt - stb_base, 0);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    idle(10);
    chk(stb_cnt == stb_base, "R7", "partial byte dropped", stb_cnt - stb_base, 0);
    chk(cfg_now() == 6'b000010, "R3", "fields kept after cut byte", cfg_now(), 6'b000010);
  endtask

  initial begin
    res_list[0] = '0; res_list[1] = '0; res_list[2] = '0; res_list[3] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    t_single;
    t_back_to_back;
    t_abort;
    t_deselect;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule